// File: doc/BRIEF.md
# External Interrupt Request Latch and Vector-Fetch Controller

This block sits beside the fetch stage of a three-stage fetch/decode/execute core. It conditions two active-low external interrupt request pins and decides, every cycle, whether the next fetch comes from the program counter or from an interrupt vector. Each pin has a two-bit enable/priority value and a mode bit that selects falling-edge or low-level triggering. A granted request replaces normal fetches with two vector words taken from consecutive addresses on consecutive cycles.

A hardware request counts as serviced only when its second vector word is fetched. If a software-interrupt opcode is in decode while the first vector word of a hardware request is being fetched, that fetch is thrown away and the two software-interrupt vector words are fetched in its place. The hardware request stays pending and is served afterwards. Instruction execution, stack handling and the wider priority register map are not part of the block.

Top module: `irq_vec_ctrl`

## Requirements
- R1: A pin whose priority field is 00 is disabled. No request on it produces a vector fetch in either trigger mode.
- R2: With mode = 1 (edge), a 1-to-0 transition of the pin is detected after a two-flop synchroniser and held in a latch. The latch is held clear for as long as the pin is disabled, so a falling edge seen while disabled is not remembered once the pin is enabled.
- R3: With mode = 0 (level), a request exists while the synchronised pin is low and the pin is enabled. If the pin is disabled before the first vector word is fetched, the request is cancelled.
- R4: Once the first vector word of a hardware request is fetched, the second word is fetched on the next cycle, even if the pin is disabled in between. The exception is the software-interrupt override of R7.
- R5: The vector word address is VEC_BASE + 2*src + word. The source index src is 0 for pin A, 1 for pin B and 2 for the software interrupt. The word index is 0 for the first word and 1 for the second.
- R6: An edge request is cleared only when its second vector word is fetched. In that cycle ack_o is 1 and ack_src_o carries the source index.
- R7: If decode_swi_i is 1 in a cycle whose fetch is the first vector word of a hardware request, the next two fetches are the software-interrupt words. There is no acknowledge for the hardware request at that point, and it is served afterwards.
- R8: When both pins are pending, the higher priority field wins and pin A wins a tie. A software interrupt in decode beats any hardware request.
- R9: After reset, and in every cycle with no vector fetch, fetch_vec_o is 0 and fetch_addr_o equals the pc_i of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a_n | input | 1 | Interrupt request pin A, active low |
| pin_b_n | input | 1 | Interrupt request pin B, active low |
| mode_a | input | 1 | Pin A trigger: 1 edge, 0 level |
| mode_b | input | 1 | Pin B trigger: 1 edge, 0 level |
| prio_a | input | 2 | Pin A enable/priority, 00 disabled |
| prio_b | input | 2 | Pin B enable/priority, 00 disabled |
| pc_i | input | AW | Address of the next normal fetch |
| decode_swi_i | input | 1 | Instruction in decode is a software interrupt |
| fetch_addr_o | output | AW | Address fetched this cycle |
| fetch_vec_o | output | 1 | This fetch is a vector word |
| fetch_word_o | output | 1 | Vector word index (0 first, 1 second) |
| ack_o | output | 1 | Hardware request serviced this cycle |
| ack_src_o | output | 2 | Source index of the serviced request |

## Verification
Two events can land in the same cycle: a software interrupt arriving in decode, and the first vector fetch of a hardware request. The bench waits until the fetch output shows the first word of pin A's vector, then raises decode_swi_i in exactly that cycle. It then expects the two software-interrupt addresses, no acknowledge, and after them pin A's two words with the acknowledge on the second. A second coincidence, a level request being disabled in the cycle its pending state first appears, is provoked by counting synchroniser cycles. It is judged by the absence of any vector fetch afterwards.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_W   = 2;
  localparam int NPIN    = 2;
  localparam logic [SRC_W-1:0] SRC_A   = 2'd0;
  localparam logic [SRC_W-1:0] SRC_B   = 2'd1;
  localparam logic [SRC_W-1:0] SRC_SWI = 2'd2;

  typedef enum logic [2:0] {
    ST_NORM,
    ST_HW1,
    ST_HW2,
    ST_SW1,
    ST_SW2
  } fetch_st_e;
endpackage

// File: rtl/irq_pin_cond.sv
module irq_pin_cond (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_n,
  input  logic       mode_edge,
  input  logic [1:0] prio,
  input  logic       clr,
  output logic       pend_o
);
  logic s1, s2, s3;
  logic edge_lat;
  logic en;
  logic fall;

  assign en   = (prio != 2'b00);
  assign fall = s3 & ~s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= pin_n;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en || !mode_edge)
      edge_lat <= 1'b0;
    else
      edge_lat <= (edge_lat & ~clr) | fall;
  end

  assign pend_o = en & (mode_edge ? edge_lat : ~s2);

  p_lat_held_r2: assert property (@(posedge clk) disable iff (rst)
    (prio == 2'b00) |=> !edge_lat || $past(en));

  p_edge_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (edge_lat && !clr && en && mode_edge && $stable(prio)) |=> (edge_lat || !en || !mode_edge));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [NPIN-1:0]  pend,
  input  logic [1:0]       prio_a,
  input  logic [1:0]       prio_b,
  output logic             any_o,
  output logic [SRC_W-1:0] win_o
);
  always_comb begin
    any_o = |pend;
    if (pend[0] && pend[1])
      win_o = (prio_b > prio_a) ? SRC_B : SRC_A;
    else if (pend[1])
      win_o = SRC_B;
    else
      win_o = SRC_A;
  end

  always_comb begin
    if (any_o)
      p_win_pending_r8: assert (pend[win_o]);
  end
endmodule

// File: rtl/irq_fetch_seq.sv
module irq_fetch_seq
  import irq_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] VEC_BASE = 16'h0010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    pc_i,
  input  logic             swi_i,
  input  logic             any_i,
  input  logic [SRC_W-1:0] win_i,
  output logic [NPIN-1:0]  clr_o,
  output logic [AW-1:0]    fetch_addr_o,
  output logic             fetch_vec_o,
  output logic             fetch_word_o,
  output logic             ack_o,
  output logic [SRC_W-1:0] ack_src_o
);
  fetch_st_e        st, nxt;
  logic [SRC_W-1:0] src, nxt_src;
  logic             nxt_word;
  logic [AW-1:0]    vec_addr;

  always_comb begin
    nxt     = ST_NORM;
    nxt_src = src;
    case (st)
      ST_HW1: begin
        if (swi_i) begin
          nxt     = ST_SW1;
          nxt_src = SRC_SWI;
        end else begin
          nxt = ST_HW2;
        end
      end
      ST_SW1: nxt = ST_SW2;
      default: begin
        if (swi_i) begin
          nxt     = ST_SW1;
          nxt_src = SRC_SWI;
        end else if (any_i) begin
          nxt     = ST_HW1;
          nxt_src = win_i;
        end
      end
    endcase
  end

  assign nxt_word = (nxt == ST_HW2) || (nxt == ST_SW2);
  assign vec_addr = VEC_BASE + AW'({nxt_src, 1'b0}) + AW'(nxt_word);

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_clr
      assign clr_o[i] = (nxt == ST_HW2) && (nxt_src == SRC_W'(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_NORM;
      src          <= SRC_A;
      fetch_addr_o <= pc_i;
      fetch_vec_o  <= 1'b0;
      fetch_word_o <= 1'b0;
      ack_o        <= 1'b0;
      ack_src_o    <= SRC_A;
    end else begin
      st           <= nxt;
      src          <= nxt_src;
      fetch_addr_o <= (nxt == ST_NORM) ? pc_i : vec_addr;
      fetch_vec_o  <= (nxt != ST_NORM);
      fetch_word_o <= nxt_word;
      ack_o        <= (nxt == ST_HW2);
      ack_src_o    <= nxt_src;
    end
  end

  p_second_follows_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HW1 && !swi_i) |=> (st == ST_HW2 && $stable(src)));

  p_swi_preempt_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HW1 && swi_i) |=> (st == ST_SW1 && !ack_o));

  p_sw_pair_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SW1) |=> (st == ST_SW2));

  p_consec_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (fetch_vec_o && fetch_word_o) |-> (fetch_addr_o == $past(fetch_addr_o) + AW'(1)));

  p_ack_second_r6: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (fetch_vec_o && fetch_word_o && ack_src_o != SRC_SWI));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] VEC_BASE = 16'h0010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin_a_n,
  input  logic          pin_b_n,
  input  logic          mode_a,
  input  logic          mode_b,
  input  logic [1:0]    prio_a,
  input  logic [1:0]    prio_b,
  input  logic [AW-1:0] pc_i,
  input  logic          decode_swi_i,
  output logic [AW-1:0] fetch_addr_o,
  output logic          fetch_vec_o,
  output logic          fetch_word_o,
  output logic          ack_o,
  output logic [1:0]    ack_src_o
);
  logic [NPIN-1:0]  pins_n, modes, pend, clr;
  logic [1:0]       prios [NPIN];
  logic             any;
  logic [SRC_W-1:0] win;

  assign pins_n   = {pin_b_n, pin_a_n};
  assign modes    = {mode_b, mode_a};
  assign prios[0] = prio_a;
  assign prios[1] = prio_b;

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      irq_pin_cond u_pin (
        .clk       (clk),
        .rst       (rst),
        .pin_n     (pins_n[i]),
        .mode_edge (modes[i]),
        .prio      (prios[i]),
        .clr       (clr[i]),
        .pend_o    (pend[i])
      );
    end
  endgenerate

  irq_arbiter u_arb (
    .pend   (pend),
    .prio_a (prio_a),
    .prio_b (prio_b),
    .any_o  (any),
    .win_o  (win)
  );

  irq_fetch_seq #(.AW(AW), .VEC_BASE(VEC_BASE)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .pc_i         (pc_i),
    .swi_i        (decode_swi_i),
    .any_i        (any),
    .win_i        (win),
    .clr_o        (clr),
    .fetch_addr_o (fetch_addr_o),
    .fetch_vec_o  (fetch_vec_o),
    .fetch_word_o (fetch_word_o),
    .ack_o        (ack_o),
    .ack_src_o    (ack_src_o)
  );

  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (prio_a == 2'b00 && prio_b == 2'b00 && !decode_swi_i && !fetch_vec_o) |=> !fetch_vec_o);
endmodule

// File: tb/tb_irq_vec_ctrl.sv
module tb_irq_vec_ctrl;
  localparam int AW = 16;
  localparam logic [AW-1:0] BASE = 16'h0010;

  logic clk = 1'b0;
  logic rst;
  logic pin_a_n, pin_b_n, mode_a, mode_b, decode_swi_i;
  logic [1:0] prio_a, prio_b;
  logic [AW-1:0] pc_i, fetch_addr_o;
  logic fetch_vec_o, fetch_word_o, ack_o;
  logic [1:0] ack_src_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_vec_ctrl #(.AW(AW), .VEC_BASE(BASE)) dut (
    .clk(clk), .rst(rst), .pin_a_n(pin_a_n), .pin_b_n(pin_b_n),
    .mode_a(mode_a), .mode_b(mode_b), .prio_a(prio_a), .prio_b(prio_b),
    .pc_i(pc_i), .decode_swi_i(decode_swi_i), .fetch_addr_o(fetch_addr_o),
    .fetch_vec_o(fetch_vec_o), .fetch_word_o(fetch_word_o),
    .ack_o(ack_o), .ack_src_o(ack_src_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish (act %0d cycles, exp < 20000)", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act 0x%0h exp 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_vec(input int maxc, output bit found);
    found = 0;
    for (int i = 0; i < maxc && !found; i++) begin
      step();
      if (fetch_vec_o) found = 1;
    end
  endtask

  task automatic expect_vec(input string tag, input logic [AW-1:0] addr, input bit word, input bit ack);
    chk(fetch_vec_o && fetch_addr_o == addr && fetch_word_o == word && ack_o == ack,
        tag, {fetch_vec_o, ack_o, fetch_addr_o}, {1'b1, ack, addr});
  endtask

  task automatic expect_quiet(input string tag, input int n);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (fetch_vec_o) seen = 1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic idle_pins();
    pin_a_n = 1; pin_b_n = 1; decode_swi_i = 0;
    step(5);
  endtask

  task automatic t_reset();
    rst = 1; pin_a_n = 1; pin_b_n = 1; mode_a = 1; mode_b = 1;
    prio_a = 0; prio_b = 0; pc_i = 16'h0100; decode_swi_i = 0;
    step(3);
    chk(!fetch_vec_o && !ack_o, "R9 reset state", {fetch_vec_o, ack_o}, 0);
    rst = 0;
    pc_i = 16'h0234;
    step();
    chk(!fetch_vec_o && fetch_addr_o == 16'h0234, "R9 normal fetch follows pc", fetch_addr_o, 16'h0234);
  endtask

  task automatic t_edge_a();
    bit f;
    mode_a = 1; prio_a = 2'd1;
    step(); pin_a_n = 0;
    wait_vec(10, f);
    expect_vec("R5 edge A first word", BASE + 16'd0, 0, 0);
    step();
    expect_vec("R6 edge A second word ack", BASE + 16'd1, 1, 1);
    chk(ack_src_o == 2'd0, "R6 ack source A", ack_src_o, 0);
    expect_quiet("R2 edge consumed, pin held low", 10);
    idle_pins();
  endtask

  task automatic t_disabled_edge();
    mode_a = 1; prio_a = 2'd0;
    pin_a_n = 0;
    expect_quiet("R1 disabled pin ignored", 8);
    prio_a = 2'd1;
    expect_quiet("R2 edge while disabled not remembered", 10);
    idle_pins();
  endtask

  task automatic t_level_b();
    bit f;
    mode_b = 0; prio_b = 2'd1;
    pin_b_n = 0;
    wait_vec(10, f);
    expect_vec("R3 level B first word", BASE + 16'd2, 0, 0);
    step();
    expect_vec("R5 level B second word", BASE + 16'd3, 1, 1);
    chk(ack_src_o == 2'd1, "R6 ack source B", ack_src_o, 1);
    prio_b = 2'd0; pin_b_n = 1;
    step(6);
    prio_b = 2'd1;
    idle_pins();
    pin_b_n = 0;
    step(2);
    prio_b = 2'd0;
    expect_quiet("R3 level cancelled before fetch", 10);
    prio_b = 2'd1;
    wait_vec(10, f);
    expect_vec("R4 level B first word again", BASE + 16'd2, 0, 0);
    prio_b = 2'd0;
    step();
    expect_vec("R4 second word despite disable", BASE + 16'd3, 1, 1);
    idle_pins();
  endtask

  task automatic t_swi_preempt();
    bit f;
    mode_a = 1; prio_a = 2'd1; prio_b = 2'd0;
    pin_a_n = 0;
    wait_vec(10, f);
    expect_vec("R7 A first word before override", BASE + 16'd0, 0, 0);
    decode_swi_i = 1;
    step();
    decode_swi_i = 0;
    expect_vec("R7 SWI first word replaces A", BASE + 16'd4, 0, 0);
    step();
    expect_vec("R7 SWI second word no ack", BASE + 16'd5, 1, 0);
    step();
    expect_vec("R7 A still pending first", BASE + 16'd0, 0, 0);
    step();
    expect_vec("R7 A served after SWI", BASE + 16'd1, 1, 1);
    idle_pins();
  endtask

  task automatic t_priority(input bit tie);
    bit f;
    string tg;
    mode_a = 1; mode_b = 1;
    prio_a = tie ? 2'd2 : 2'd1;
    prio_b = 2'd2;
    tg = tie ? "R8 tie" : "R8 higher B";
    pin_a_n = 0; pin_b_n = 0;
    wait_vec(10, f);
    if (tie) begin
      expect_vec({tg, " A first"}, BASE + 16'd0, 0, 0);
      step(); expect_vec({tg, " A second"}, BASE + 16'd1, 1, 1);
      step(); expect_vec({tg, " B first"}, BASE + 16'd2, 0, 0);
      step(); expect_vec({tg, " B second"}, BASE + 16'd3, 1, 1);
    end else begin
      expect_vec({tg, " B first"}, BASE + 16'd2, 0, 0);
      step(); expect_vec({tg, " B second"}, BASE + 16'd3, 1, 1);
      step(); expect_vec({tg, " A first"}, BASE + 16'd0, 0, 0);
      step(); expect_vec({tg, " A second"}, BASE + 16'd1, 1, 1);
    end
    idle_pins();
    prio_a = 0; prio_b = 0;
  endtask

  task automatic t_swi_idle();
    pc_i = 16'h0300;
    decode_swi_i = 1;
    step();
    decode_swi_i = 0;
    expect_vec("R8 SWI from idle first", BASE + 16'd4, 0, 0);
    step();
    expect_vec("R5 SWI from idle second", BASE + 16'd5, 1, 0);
    step();
    chk(!fetch_vec_o && fetch_addr_o == 16'h0300, "R9 back to normal fetch", fetch_addr_o, 16'h0300);
  endtask

  initial begin
    t_reset();
    t_edge_a();
    t_disabled_edge();
    t_level_b();
    t_swi_preempt();
    t_priority(0);
    t_priority(1);
    t_swi_idle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule